// File: doc/BRIEF.md
# TDM Bus Clock and Frame-Pulse Generator

This block derives a family of TDM bus clocks, each paired with an 8 kHz frame pulse, from one fast reference clock. The reference runs at 65.536 MHz nominal, so a frame of 125 us is `FRAME_CYC` = 8192 reference cycles. A single frame counter drives every output, which keeps all of them phase-aligned at the frame boundary.

There are four clock/frame-pulse pairs:

- Pairs 0, 1 and 2 run at 4.096, 8.192 and 16.384 MHz.
- Pair 3 has a rate chosen by a 2-bit code.

A fifth, auxiliary clock runs at either 1.544 or 2.048 MHz. It is built with a fractional accumulator that is restarted at every frame boundary.

Static configuration ports set the following:

- the polarity of each clock and each frame pulse;
- the framing style of each frame pulse, either ST-BUS (straddling the boundary) or GCI (starting at the boundary);
- a divided-slave mode. This mode takes the rate of the slower input clock as a code and silences every output that would run faster than that input.

All configuration is captured into a shadow copy only at the frame boundary. A change on the ports therefore never produces a runt pulse.

Top module: `tdm_clkgen`

## Requirements
- R1: The frame counter wraps every `FRAME_CYC` reference cycles. Every enabled frame pulse is asserted exactly once per frame, aligned to the same boundary. Outputs are registered: the output after clock edge n reflects frame position n-1.
- R2: Pairs 0, 1 and 2 divide the reference by 16, 8 and 4 (4.096, 8.192 and 16.384 MHz). With the polarity bit at 0 (negative format), a clock is low in the first half and high in the second half of each of its periods. Its falling edge therefore coincides with the frame boundary.
- R3: The pair 3 rate code `p3_rate` selects the reference divider, and the frame-pulse width follows the chosen rate:
  - 0 = /16, 4.096 MHz
  - 1 = /8, 8.192 MHz
  - 2 = /4, 16.384 MHz
  - 3 = /2, 32.768 MHz
- R4: In ST-BUS framing (`fp_gci` bit = 0), a frame pulse is active low. It covers the last half clock period of a frame and the first half period of the next, so its total width is one period of its paired clock.
- R5: In GCI framing (`fp_gci` bit = 1), a frame pulse is active high. It starts at the boundary and lasts one paired-clock period. Each pair selects its framing independently of the others.
- R6: `ck_pos[i]` set to 1 inverts clock i, where bit 4 is the auxiliary clock. `fp_pos[i]` set to 1 inverts frame pulse i.
- R7: While `slave_mode` is 1, a pair whose rate code exceeds `slave_rate` (same encoding as R3) is held inactive. Its clock stays at the level of its polarity bit, and its frame pulse stays at its deasserted level. The auxiliary clock is also held at its polarity level in this mode.
- R8: The auxiliary clock toggles 2×193 times per frame when `aux_e1` = 0 (1.544 MHz average), and 2×256 times per frame when `aux_e1` = 1 (2.048 MHz). The jitter on any edge is at most one reference period.
- R9: Configuration ports are sampled only in the last cycle of a frame. A change made mid-frame leaves the rest of that frame unaltered.
- R10: The synchronous reset forces the following state:
  - `ck_out` = 0, `fp_out` = all ones, `aux_ck` = 0;
  - the shadow configuration set to all zeros, so the first frame after reset uses negative clocks, ST-BUS framing, 4.096 MHz on pair 3, 1.544 MHz on the auxiliary clock and master mode, whatever the ports hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| slave_mode | input | 1 | 1 = divided-slave gating active |
| slave_rate | input | 2 | Input clock rate code (R3 encoding) |
| p3_rate | input | 2 | Pair 3 rate code |
| aux_e1 | input | 1 | Auxiliary clock: 0 = 1.544 MHz, 1 = 2.048 MHz |
| ck_pos | input | 5 | Clock polarity per output, bit 4 = auxiliary |
| fp_pos | input | 4 | Frame-pulse polarity per pair |
| fp_gci | input | 4 | Frame-pulse framing per pair: 0 = ST-BUS, 1 = GCI |
| ck_out | output | 4 | Pair clocks |
| fp_out | output | 4 | Pair frame pulses |
| aux_ck | output | 1 | 1.544/2.048 MHz clock |

## Verification
A vector table drives whole-frame comparisons of all four pairs against a position-based model under these patterns:

- **Default settings.** Separates the fixed dividers.
- **Every pair 3 rate.** Shows whether the pulse width follows the chosen rate.
- **Mixed per-pair framing and polarity masks.** Catches bits wired to the wrong pair, or a framing applied globally.
- **Several slave input rates.** Locates exactly which pairs must go silent.

Toggle counts of the auxiliary clock over one frame separate the two line rates and confirm that the clock is silenced in slave mode. Directed cases change settings in mid-frame to confirm boundary-only updates, and load non-default ports during reset to confirm that the first frame still runs on the reset configuration.

// File: rtl/tdm_clkgen_pkg.sv
package tdm_clkgen_pkg;

  typedef logic [1:0] rate_code_t;

  typedef struct packed {
    logic       slave_mode;
    rate_code_t slave_rate;
    rate_code_t p3_rate;
    logic       aux_e1;
    logic [4:0] ck_pos;
    logic [3:0] fp_pos;
    logic [3:0] fp_gci;
  } tdm_cfg_t;

endpackage

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr
  import tdm_clkgen_pkg::*;
#(
  parameter int FRAME_CYC = 8192,
  localparam int CW = $clog2(FRAME_CYC)
) (
  input  logic          clk,
  input  logic          rst,
  input  tdm_cfg_t      cfg_in,
  output logic [CW-1:0] cnt,
  output logic          frame_last,
  output tdm_cfg_t      cfg_q
);

  localparam logic [CW-1:0] LAST = CW'(FRAME_CYC - 1);

  assign frame_last = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      cfg_q <= '0;
    end else begin
      cnt <= frame_last ? '0 : cnt + 1'b1;
      if (frame_last) cfg_q <= cfg_in;
    end
  end

  // R1: counter returns to zero after the last position of a frame
  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (cnt == LAST) |=> (cnt == '0));

  // R9: shadow configuration moves only across a frame boundary
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt != LAST) |=> $stable(cfg_q));

endmodule

// File: rtl/tdm_pair_gen.sv
module tdm_pair_gen
  import tdm_clkgen_pkg::*;
#(
  parameter int FRAME_CYC = 8192,
  parameter int SLOW_LOG2 = 4,
  localparam int CW = $clog2(FRAME_CYC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  rate_code_t    rate,
  input  logic          en,
  input  logic          ck_pos,
  input  logic          fp_pos,
  input  logic          fp_gci,
  output logic          ck_o,
  output logic          fp_o
);

  int   lg;
  int   period;
  int   half;
  int   pos;
  logic ck_raw;
  logic st_act;
  logic fp_native;
  logic ck_nxt;
  logic fp_nxt;

  always_comb begin
    lg        = SLOW_LOG2 - int'(rate);
    period    = 1 << lg;
    half      = period / 2;
    pos       = int'(cnt);
    ck_raw    = ((pos >> (lg - 1)) & 1) == 1;
    st_act    = (pos < half) || (pos >= FRAME_CYC - half);
    fp_native = fp_gci ? (pos < period) : !st_act;
    ck_nxt    = en ? (ck_raw ^ ck_pos) : ck_pos;
    fp_nxt    = en ? (fp_native ^ fp_pos) : (!fp_gci ^ fp_pos);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_o <= 1'b0;
      fp_o <= 1'b1;
    end else begin
      ck_o <= ck_nxt;
      fp_o <= fp_nxt;
    end
  end

  // R7: a gated pair keeps both outputs frozen
  p_gated_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!en && $past(!en) && $stable(ck_pos) && $stable(fp_pos) && $stable(fp_gci))
      |=> ($stable(ck_o) && $stable(fp_o)));

endmodule

// File: rtl/tdm_aux_clk.sv
module tdm_aux_clk #(
  parameter int FRAME_CYC = 8192,
  parameter int T1_LINES  = 193,
  parameter int E1_LINES  = 256,
  localparam int AW = $clog2(FRAME_CYC) + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_last,
  input  logic e1,
  input  logic en,
  input  logic pol,
  output logic ck_o
);

  localparam logic [AW-1:0] FRAME_W = AW'(FRAME_CYC);
  localparam logic [AW-1:0] STEP_T1 = AW'(2 * T1_LINES);
  localparam logic [AW-1:0] STEP_E1 = AW'(2 * E1_LINES);

  logic [AW-1:0] acc;
  logic [AW-1:0] sum;
  logic          ph;

  assign sum = acc + (e1 ? STEP_E1 : STEP_T1);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      ph   <= 1'b0;
      ck_o <= 1'b0;
    end else begin
      if (frame_last) begin
        acc <= '0;
        ph  <= 1'b0;
      end else if (sum >= FRAME_W) begin
        acc <= sum - FRAME_W;
        ph  <= ~ph;
      end else begin
        acc <= sum;
      end
      ck_o <= en ? (ph ^ pol) : pol;
    end
  end

  // R8: accumulator residue stays below one frame
  p_acc_bound_r8: assert property (@(posedge clk) disable iff (rst)
    acc < FRAME_W);

endmodule

// File: rtl/tdm_clkgen.sv
module tdm_clkgen
  import tdm_clkgen_pkg::*;
#(
  parameter int FRAME_CYC = 8192,
  parameter int SLOW_LOG2 = 4,
  parameter int T1_LINES  = 193,
  parameter int E1_LINES  = 256,
  parameter int NPAIR     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slave_mode,
  input  logic [1:0]       slave_rate,
  input  logic [1:0]       p3_rate,
  input  logic             aux_e1,
  input  logic [NPAIR:0]   ck_pos,
  input  logic [NPAIR-1:0] fp_pos,
  input  logic [NPAIR-1:0] fp_gci,
  output logic [NPAIR-1:0] ck_out,
  output logic [NPAIR-1:0] fp_out,
  output logic             aux_ck
);

  localparam int CW = $clog2(FRAME_CYC);

  tdm_cfg_t      cfg_in;
  tdm_cfg_t      cfg_q;
  logic [CW-1:0] cnt;
  logic          frame_last;

  always_comb begin
    cfg_in            = '0;
    cfg_in.slave_mode = slave_mode;
    cfg_in.slave_rate = slave_rate;
    cfg_in.p3_rate    = p3_rate;
    cfg_in.aux_e1     = aux_e1;
    cfg_in.ck_pos     = ck_pos;
    cfg_in.fp_pos     = fp_pos;
    cfg_in.fp_gci     = fp_gci;
  end

  tdm_frame_ctr #(.FRAME_CYC(FRAME_CYC)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .cfg_in     (cfg_in),
    .cnt        (cnt),
    .frame_last (frame_last),
    .cfg_q      (cfg_q)
  );

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    rate_code_t rate;
    logic       en;
    if (i == NPAIR - 1) begin : g_sel
      assign rate = cfg_q.p3_rate;
    end else begin : g_fix
      assign rate = 2'(i);
    end
    assign en = !cfg_q.slave_mode || (rate <= cfg_q.slave_rate);

    tdm_pair_gen #(.FRAME_CYC(FRAME_CYC), .SLOW_LOG2(SLOW_LOG2)) u_pair (
      .clk    (clk),
      .rst    (rst),
      .cnt    (cnt),
      .rate   (rate),
      .en     (en),
      .ck_pos (cfg_q.ck_pos[i]),
      .fp_pos (cfg_q.fp_pos[i]),
      .fp_gci (cfg_q.fp_gci[i]),
      .ck_o   (ck_out[i]),
      .fp_o   (fp_out[i])
    );
  end

  tdm_aux_clk #(
    .FRAME_CYC (FRAME_CYC),
    .T1_LINES  (T1_LINES),
    .E1_LINES  (E1_LINES)
  ) u_aux (
    .clk        (clk),
    .rst        (rst),
    .frame_last (frame_last),
    .e1         (cfg_q.aux_e1),
    .en         (!cfg_q.slave_mode),
    .pol        (cfg_q.ck_pos[NPAIR]),
    .ck_o       (aux_ck)
  );

endmodule

// File: tb/tdm_clkgen_bench.sv
module tdm_clkgen_bench;

  localparam int FRAME = 1024;
  localparam int NVEC  = 8;

  typedef struct packed {
    logic       slv;
    logic [1:0] srate;
    logic [1:0] p3;
    logic       e1;
    logic [4:0] ckp;
    logic [3:0] fpp;
    logic [3:0] gci;
  } bcfg_t;

  localparam bcfg_t VEC [NVEC] = '{
    '{1'b0, 2'd0, 2'd0, 1'b0, 5'b00000, 4'b0000, 4'b0000},
    '{1'b0, 2'd0, 2'd3, 1'b1, 5'b00000, 4'b0000, 4'b1111},
    '{1'b0, 2'd0, 2'd2, 1'b0, 5'b10101, 4'b0110, 4'b1010},
    '{1'b0, 2'd0, 2'd1, 1'b1, 5'b11111, 4'b1111, 4'b0101},
    '{1'b1, 2'd1, 2'd3, 1'b0, 5'b00000, 4'b0000, 4'b0000},
    '{1'b1, 2'd1, 2'd1, 1'b1, 5'b01010, 4'b1001, 4'b0011},
    '{1'b1, 2'd0, 2'd0, 1'b0, 5'b11111, 4'b1111, 4'b1111},
    '{1'b1, 2'd3, 2'd3, 1'b1, 5'b00000, 4'b0000, 4'b1100}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  bcfg_t      drv = '0;
  logic [3:0] ck_out;
  logic [3:0] fp_out;
  logic       aux_ck;

  int nchk = 0;
  int nbad = 0;

  always #5 clk = ~clk;

  tdm_clkgen #(.FRAME_CYC(FRAME)) u_tdm_clkgen (
    .clk        (clk),
    .rst        (rst),
    .slave_mode (drv.slv),
    .slave_rate (drv.srate),
    .p3_rate    (drv.p3),
    .aux_e1     (drv.e1),
    .ck_pos     (drv.ckp),
    .fp_pos     (drv.fpp),
    .fp_gci     (drv.gci),
    .ck_out     (ck_out),
    .fp_out     (fp_out),
    .aux_ck     (aux_ck)
  );

  // frame position and configuration that the visible outputs stand for
  int    tb_cnt = 0;
  int    tb_pos = 0;
  bcfg_t tb_sh   = '0;
  bcfg_t tb_used = '0;
  logic  tb_valid = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      tb_cnt   <= 0;
      tb_sh    <= '0;
      tb_valid <= 1'b0;
    end else begin
      tb_pos   <= tb_cnt;
      tb_used  <= tb_sh;
      tb_valid <= 1'b1;
      tb_cnt   <= (tb_cnt == FRAME - 1) ? 0 : tb_cnt + 1;
      if (tb_cnt == FRAME - 1) tb_sh <= drv;
    end
  end

  function automatic logic [1:0] exp_pair(input int i, input int pos, input bcfg_t c);
    int   rate, div, half;
    logic en, ck, fp, st_act;
    rate   = (i == 3) ? int'(c.p3) : i;
    div    = 16 >> rate;
    half   = div / 2;
    en     = !c.slv || (rate <= int'(c.srate));
    st_act = (pos < half) || (pos >= FRAME - half);
    if (!en) begin
      ck = c.ckp[i];
      fp = !c.gci[i] ^ c.fpp[i];
    end else begin
      ck = ((pos % div) >= half) ^ c.ckp[i];
      fp = (c.gci[i] ? (pos < div) : !st_act) ^ c.fpp[i];
    end
    return {ck, fp};
  endfunction

  function automatic string vec_tag(input int v);
    case (v)
      0: return "R1 R2 R3 R4";
      1: return "R3 R5";
      2: return "R3 R5 R6";
      3: return "R3 R5 R6";
      4: return "R7";
      5: return "R7 R6";
      6: return "R7 R5 R6";
      default: return "R7 R3";
    endcase
  endfunction

  // compare pairs at every negedge until stop_pos has been checked
  task automatic check_span(input bit fixed_en, input bcfg_t fixed, input int stop_pos,
                            input string tag);
    int   bad = 0;
    logic [3:0] eck, efp, ack, afp;
    int   at = 0;
    bit   done = 0;
    while (!done) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        logic [1:0] e;
        e = exp_pair(i, tb_pos, fixed_en ? fixed : tb_used);
        if ({ck_out[i], fp_out[i]} != e && bad == 0) begin
          at = tb_pos; ack = ck_out; afp = fp_out;
          eck = 'x; efp = 'x;
          for (int j = 0; j < 4; j++) begin
            logic [1:0] f;
            f = exp_pair(j, tb_pos, fixed_en ? fixed : tb_used);
            eck[j] = f[1]; efp[j] = f[0];
          end
        end
        if ({ck_out[i], fp_out[i]} != e) bad++;
      end
      if (tb_pos == stop_pos) done = 1;
    end
    nchk++;
    if (bad != 0) begin
      nbad++;
      $display("FAIL %s: pos %0d ck/fp actual %b/%b expected %b/%b", tag, at, ack, afp, eck, efp);
    end
  endtask

  // one full frame of pair compares plus auxiliary toggle count (R8)
  task automatic check_frame(input string tag);
    int   tog = 0;
    int   exp_tog;
    logic prev;
    bcfg_t c;
    while (!(tb_valid && tb_pos == FRAME / 2)) @(negedge clk);
    while (tb_pos != FRAME - 1) @(negedge clk);
    fork
      check_span(1'b0, '0, FRAME - 1, tag);
      begin
        @(negedge clk);
        c = tb_used;
        prev = aux_ck;
        for (int k = 1; k < FRAME; k++) begin
          @(negedge clk);
          if (aux_ck != prev) tog++;
          prev = aux_ck;
        end
      end
    join
    exp_tog = c.slv ? 0 : (c.e1 ? 2 * 256 - 1 : 2 * 193 - 1);
    nchk++;
    if (tog != exp_tog) begin
      nbad++;
      $display("FAIL R8 (%s): aux toggles actual %0d expected %0d", tag, tog, exp_tog);
    end
  endtask

  initial begin
    #(10 * 150000);
    nbad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    bcfg_t old;
    bcfg_t nw;
    // R10: reset state, with non-default ports already driven
    drv = VEC[2];
    repeat (3) @(posedge clk);
    @(negedge clk);
    nchk++;
    if (ck_out != 4'b0000 || fp_out != 4'b1111 || aux_ck != 1'b0) begin
      nbad++;
      $display("FAIL R10: reset ck/fp/aux actual %b/%b/%b expected 0000/1111/0", ck_out, fp_out, aux_ck);
    end
    rst = 1'b0;
    // R10 R9: first frame after reset runs on the all-zero configuration
    while (!(tb_valid && tb_pos == 0)) @(negedge clk);
    begin
      int bad0 = 0;
      for (int i = 0; i < 4; i++)
        if ({ck_out[i], fp_out[i]} != exp_pair(i, 0, '0)) bad0++;
      nchk++;
      if (bad0 != 0) begin
        nbad++;
        $display("FAIL R10: pos 0 ck/fp actual %b/%b expected default", ck_out, fp_out);
      end
    end
    check_span(1'b1, '0, FRAME - 1, "R10 R9 default frame");

    // table of configurations, each judged over one full frame
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      drv = VEC[v];
      check_frame(vec_tag(v));
    end

    // R9: mid-frame change must not reach the outputs before the boundary
    @(negedge clk);
    drv = VEC[0];
    check_frame("R9 setup");
    while (tb_pos != FRAME / 4) @(negedge clk);
    old = tb_used;
    nw  = VEC[0];
    nw.p3  = 2'd3;
    nw.ckp = 5'b11111;
    nw.gci = 4'b1111;
    drv = nw;
    check_span(1'b1, old, FRAME - 1, "R9 rest of frame keeps old setting");
    check_span(1'b1, nw, FRAME - 1, "R9 next frame takes new setting");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

endmodule